// File: doc/BRIEF.md
# Dual-Master GPIO Port Controller

A 16-pin general-purpose I/O port. Two sources can drive the pins. The processor drives them through a control word and a data word on a small register bus. An internal peripheral drives them through a direction vector and a data vector on plain input ports. For every pin the block resolves one logic level from the two drivers and a per-pin pull-up. A read of the data word returns these resolved levels.

Up to four listeners can register a 16-bit trigger mask. Registration takes the lowest free slot and reports an error when no slot is free. On every processor write to the control or data word, the block compares the resolved lines before and after the write. The line levels are computed with the same peripheral inputs on both sides of the comparison. A listener whose mask overlaps the changed bits gets a one-cycle notify pulse. A change driven only by the peripheral notifies nobody.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the control word and the data word read as 0, the resolved lines read as 0, and no notify, acknowledge or error pulse is active.
- R2: In the control word (word index 0, 32 bits), bit 2n enables the processor's output drive of pin n, and bit 2n+1 enables the pull-up of pin n. A read of index 0 returns the word last written.
- R3: Resolved pin n = (cpu_dir[n] & cpu_data[n]) | (periph_dir[n] & periph_data[n]) | (~(cpu_dir[n] | periph_dir[n]) & pullup[n]).
- R4: A read of the data word (word index 1) returns the resolved levels in bits 15:0, with zeros above, and does not return the value last written.
- R5: Read data and rvalid appear in the cycle after the read request. A read of an unmapped index (2 or 3) returns 0. A write to an unmapped index changes no register.
- R6: A write that leaves the resolved lines unchanged produces no notify pulse and a zero change vector.
- R7: A write that changes the resolved lines drives changed_o = old XOR new and drives notify_o[i] for every valid slot whose mask overlaps changed_o. Both outputs last one cycle and are registered on the same edge as the write.
- R8: A change on the peripheral direction or data inputs alone never produces a notify pulse.
- R9: A registration request fills the lowest-numbered free slot and answers with ack and that slot's index one cycle later.
- R10: When all four slots are in use, a registration answers with an error pulse and leaves every slot and its mask unchanged.
- R11: One control write updates the direction and the pull-up of all pins at the same time, so the change vector compares the state before the write with the state after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word index: 0 = control, 1 = data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| periph_dir_i | input | 16 | Peripheral output enable per pin |
| periph_data_i | input | 16 | Peripheral drive value per pin |
| reg_req_i | input | 1 | Listener registration request |
| reg_mask_i | input | 16 | Trigger mask of the listener that registers |
| reg_ack_o | output | 1 | Registration accepted |
| reg_err_o | output | 1 | Registration refused, no free slot |
| reg_slot_o | output | 2 | Slot index given on accept |
| notify_o | output | 4 | Per-slot notify pulse |
| changed_o | output | 16 | Changed-line vector that goes with the notify pulse |

## Verification
Most faults in the stored direction, pull-up or data bits show up in the resolved levels read back at index 1, one cycle after the read request. A fault in the before/after comparison shows up as a missing pulse, an extra pulse or a wrong change vector in the cycle right after the write. A corrupt slot table stays hidden until a later write touches the lines of that slot's mask. The bench therefore makes writes that touch masks of every slot after the table has filled. A free-slot search that picks the wrong slot shows up at once in reg_slot_o.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_resolve.sv
module gpio_port_resolve #(
  parameter int unsigned PINS = 16,
  localparam int unsigned CW  = 2 * PINS
) (
  input  logic [CW-1:0]   ctrl_i,
  input  logic [PINS-1:0] data_i,
  input  logic [PINS-1:0] pdir_i,
  input  logic [PINS-1:0] pdat_i,
  output logic [PINS-1:0] lines_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic cdir, pull;
    assign cdir = ctrl_i[2*n];
    assign pull = ctrl_i[2*n+1];
    assign lines_o[n] = (cdir & data_i[n]) | (pdir_i[n] & pdat_i[n]) |
                        (~(cdir | pdir_i[n]) & pull);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 16,
  localparam int unsigned CW  = 2 * PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CW-1:0]     bus_wdata_i,
  input  logic [PINS-1:0]   lines_i,
  output logic [CW-1:0]     ctrl_q_o,
  output logic [PINS-1:0]   data_q_o,
  output logic [CW-1:0]     ctrl_nxt_o,
  output logic [PINS-1:0]   data_nxt_o,
  output logic              wr_fire_o,
  output logic [CW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic          wr_ctrl, wr_data, rd_fire;
  logic [CW-1:0] rdata_d;

  assign wr_ctrl   = bus_valid_i & bus_write_i & (bus_addr_i == SEL_CTRL);
  assign wr_data   = bus_valid_i & bus_write_i & (bus_addr_i == SEL_DATA);
  assign wr_fire_o = wr_ctrl | wr_data;
  assign rd_fire   = bus_valid_i & ~bus_write_i;

  assign ctrl_nxt_o = wr_ctrl ? bus_wdata_i : ctrl_q_o;
  assign data_nxt_o = wr_data ? bus_wdata_i[PINS-1:0] : data_q_o;

  always_comb begin
    unique case (bus_addr_i)
      SEL_CTRL: rdata_d = ctrl_q_o;
      SEL_DATA: rdata_d = {{(CW-PINS){1'b0}}, lines_i};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o <= '0;
      data_q_o <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      ctrl_q_o <= ctrl_nxt_o;
      data_q_o <= data_nxt_o;
      rvalid_o <= rd_fire;
      if (rd_fire) rdata_o <= rdata_d;
    end
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(bus_valid_i && !bus_write_i)); // R5
  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q_o) |-> $past(bus_valid_i && bus_write_i && bus_addr_i == SEL_CTRL)); // R5
endmodule

// File: rtl/gpio_port_notify.sv
module gpio_port_notify #(
  parameter int unsigned PINS  = 16,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_fire_i,
  input  logic [PINS-1:0]  lines_old_i,
  input  logic [PINS-1:0]  lines_new_i,
  input  logic             reg_req_i,
  input  logic [PINS-1:0]  reg_mask_i,
  output logic [SLOTS-1:0] notify_o,
  output logic [PINS-1:0]  changed_o,
  output logic             reg_ack_o,
  output logic             reg_err_o,
  output logic [SW-1:0]    reg_slot_o
);
  logic [SLOTS-1:0] slot_vld_q;
  logic [PINS-1:0]  slot_mask_q [SLOTS];
  logic [PINS-1:0]  diff;
  logic [SLOTS-1:0] hit;
  logic             free_found;
  logic [SW-1:0]    free_idx;

  assign diff = wr_fire_i ? (lines_old_i ^ lines_new_i) : '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_hit
    assign hit[i] = slot_vld_q[i] & |(slot_mask_q[i] & diff);
  end

  // scan downward so the lowest free slot wins
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!slot_vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = SW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_mask_q[i] <= '0;
      notify_o   <= '0;
      changed_o  <= '0;
      reg_ack_o  <= 1'b0;
      reg_err_o  <= 1'b0;
      reg_slot_o <= '0;
    end else begin
      notify_o  <= hit;
      changed_o <= diff;
      reg_ack_o <= reg_req_i & free_found;
      reg_err_o <= reg_req_i & ~free_found;
      if (reg_req_i && free_found) begin
        slot_vld_q[free_idx]  <= 1'b1;
        slot_mask_q[free_idx] <= reg_mask_i;
        reg_slot_o            <= free_idx;
      end
    end
  end

  AST_NOTIFY_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|notify_o) |-> $past(wr_fire_i)); // R8
  AST_NOTIFY_HAS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|notify_o) |-> (changed_o != '0)); // R7
  AST_NOTIFY_VALID_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_o & ~slot_vld_q) == '0); // R7
  AST_ACK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_ack_o && reg_err_o)); // R9
  AST_ERR_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(&slot_vld_q)); // R10
  AST_SLOT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(slot_vld_q) & ~slot_vld_q) == '0); // R10
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS  = 16,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned CW   = 2 * PINS,
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CW-1:0]     bus_wdata_i,
  output logic [CW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic [PINS-1:0]   periph_dir_i,
  input  logic [PINS-1:0]   periph_data_i,
  input  logic              reg_req_i,
  input  logic [PINS-1:0]   reg_mask_i,
  output logic              reg_ack_o,
  output logic              reg_err_o,
  output logic [SW-1:0]     reg_slot_o,
  output logic [SLOTS-1:0]  notify_o,
  output logic [PINS-1:0]   changed_o
);
  logic [CW-1:0]   ctrl_q, ctrl_nxt;
  logic [PINS-1:0] data_q, data_nxt, lines_cur, lines_nxt;
  logic            wr_fire;

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .lines_i(lines_cur), .ctrl_q_o(ctrl_q), .data_q_o(data_q),
    .ctrl_nxt_o(ctrl_nxt), .data_nxt_o(data_nxt), .wr_fire_o(wr_fire),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  // same peripheral inputs on both sides: only the write can cause a difference
  gpio_port_resolve #(.PINS(PINS)) u_res_cur (
    .ctrl_i(ctrl_q), .data_i(data_q), .pdir_i(periph_dir_i),
    .pdat_i(periph_data_i), .lines_o(lines_cur)
  );
  gpio_port_resolve #(.PINS(PINS)) u_res_nxt (
    .ctrl_i(ctrl_nxt), .data_i(data_nxt), .pdir_i(periph_dir_i),
    .pdat_i(periph_data_i), .lines_o(lines_nxt)
  );

  gpio_port_notify #(.PINS(PINS), .SLOTS(SLOTS)) u_notify (
    .clk_i, .rst_ni, .wr_fire_i(wr_fire), .lines_old_i(lines_cur),
    .lines_new_i(lines_nxt), .reg_req_i, .reg_mask_i, .notify_o, .changed_o,
    .reg_ack_o, .reg_err_o, .reg_slot_o
  );
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_rvalid;
  logic [15:0] pdir = 0, pdat = 0, reg_mask = 0, changed;
  logic        reg_req = 0, reg_ack, reg_err;
  logic [1:0]  reg_slot;
  logic [3:0]  notify;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] l_rdata; logic l_rvalid;
  logic [3:0]  l_notify; logic [15:0] l_changed;
  logic        l_ack, l_err; logic [1:0] l_slot;

  gpio_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .periph_dir_i(pdir), .periph_data_i(pdat),
    .reg_req_i(reg_req), .reg_mask_i(reg_mask), .reg_ack_o(reg_ack),
    .reg_err_o(reg_err), .reg_slot_o(reg_slot), .notify_o(notify), .changed_o(changed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // fields: cpu dir, pull-up, cpu data, periph dir, periph data, expected lines
  localparam logic [95:0] VEC [8] = '{
    {16'hFFFF, 16'h0000, 16'hA5A5, 16'h0000, 16'hFFFF, 16'hA5A5},
    {16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
    {16'h0000, 16'h0000, 16'hFFFF, 16'h00FF, 16'h0F0F, 16'h000F},
    {16'hFF00, 16'h00FF, 16'h1234, 16'h0000, 16'h0000, 16'h12FF},
    {16'hF0F0, 16'h0F0F, 16'hFFFF, 16'h0F00, 16'h0000, 16'hF0FF},
    {16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    {16'hAAAA, 16'h5555, 16'h0000, 16'h5555, 16'h5555, 16'h5555},
    {16'h8001, 16'h0000, 16'h8000, 16'h0000, 16'h0000, 16'h8000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_ctrl(logic [15:0] dir, logic [15:0] pu);
    logic [31:0] w;
    for (int n = 0; n < 16; n++) begin
      w[2*n]   = dir[n];
      w[2*n+1] = pu[n];
    end
    return w;
  endfunction

  task automatic bus_op(logic wr, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    l_rdata = bus_rdata; l_rvalid = bus_rvalid; l_notify = notify; l_changed = changed;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_reg(logic [15:0] m);
    @(negedge clk);
    reg_req = 1; reg_mask = m;
    @(posedge clk); #1;
    l_ack = reg_ack; l_err = reg_err; l_slot = reg_slot;
    @(negedge clk);
    reg_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 notify", {28'h0, notify}, 32'h0);
    bus_op(0, 2'd0, 0); check("R1 ctrl", l_rdata, 32'h0);
    bus_op(0, 2'd1, 0); check("R1 lines", l_rdata, 32'h0);
    check("R5 rvalid on read", {31'h0, l_rvalid}, 32'h1);

    // R3/R4 resolution table
    for (int i = 0; i < 8; i++) begin
      logic [15:0] dir, pu, dat, pd, pv, exp;
      {dir, pu, dat, pd, pv, exp} = VEC[i];
      pdir = pd; pdat = pv;
      bus_op(1, 2'd0, pack_ctrl(dir, pu));
      bus_op(1, 2'd1, {16'hDEAD, dat});
      bus_op(0, 2'd1, 0);
      check($sformatf("R3 R4 vec%0d", i), l_rdata, {16'h0, exp});
    end
    bus_op(0, 2'd0, 0);
    check("R2 ctrl readback", l_rdata, pack_ctrl(16'h8001, 16'h0000));

    // R5 unmapped index
    bus_op(1, 2'd2, 32'hFFFF_FFFF);
    check("R5 write rvalid low", {31'h0, l_rvalid}, 32'h0);
    bus_op(0, 2'd2, 0); check("R5 unmapped read", l_rdata, 32'h0);
    bus_op(0, 2'd0, 0); check("R5 ctrl untouched", l_rdata, pack_ctrl(16'h8001, 16'h0000));
    bus_op(0, 2'd1, 0); check("R5 lines untouched", l_rdata, 32'h8000);

    // R9 registration order, R10 full
    pdir = 0; pdat = 0;
    do_reg(16'h000F); check("R9 slot0", {29'h0, l_ack, l_slot}, {29'h0, 1'b1, 2'd0});
    do_reg(16'h00F0); check("R9 slot1", {29'h0, l_ack, l_slot}, {29'h0, 1'b1, 2'd1});
    do_reg(16'h0F00); check("R9 slot2", {29'h0, l_ack, l_slot}, {29'h0, 1'b1, 2'd2});
    do_reg(16'hF000); check("R9 slot3", {29'h0, l_ack, l_slot}, {29'h0, 1'b1, 2'd3});
    do_reg(16'hFFFF); check("R10 full err", {30'h0, l_ack, l_err}, 32'h1);

    // R7 / R6 change detection
    bus_op(1, 2'd0, 32'h5555_5555);
    bus_op(1, 2'd1, 32'h0000);
    bus_op(1, 2'd1, 32'h0010);
    check("R7 changed", {16'h0, l_changed}, 32'h0010);
    check("R7 notify", {28'h0, l_notify}, 32'h2);
    bus_op(1, 2'd1, 32'h0010);
    check("R6 no notify", {28'h0, l_notify}, 32'h0);
    check("R6 no change", {16'h0, l_changed}, 32'h0);
    bus_op(1, 2'd1, 32'h8001);
    check("R7 R10 changed", {16'h0, l_changed}, 32'h8011);
    check("R7 R10 notify masks kept", {28'h0, l_notify}, 32'hB);
    @(negedge clk);
    check("R7 one-cycle pulse", {28'h0, notify}, 32'h0);

    // R8 peripheral-only change
    pdir = 16'hFFFF; pdat = 16'hFFFF;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R8 periph no notify", {28'h0, notify}, 32'h0);
    end
    bus_op(0, 2'd1, 0); check("R8 periph drives lines", l_rdata, 32'hFFFF);
    pdir = 0; pdat = 0;

    // R11 control write changes dir and pull-up together
    bus_op(1, 2'd0, 32'hAAAA_AAAA);
    check("R11 changed", {16'h0, l_changed}, 32'h7FFE);
    check("R11 notify", {28'h0, l_notify}, 32'hF);
    bus_op(0, 2'd1, 0); check("R11 lines pulled", l_rdata, 32'hFFFF);
    bus_op(1, 2'd0, 32'h0000_0001);
    check("R11 changed back", {16'h0, l_changed}, 32'hFFFE);
    bus_op(0, 2'd1, 0); check("R11 lines", l_rdata, 32'h0001);

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    bus_op(0, 2'd0, 0); check("R1 ctrl after reset", l_rdata, 32'h0);
    do_reg(16'h0001); check("R1 R9 slots cleared", {29'h0, l_ack, l_slot}, {29'h0, 1'b1, 2'd0});

    finish_run();
  end
endmodule